// File: doc/BRIEF.md
# DMA Transfer-Request Status Tracker

This block follows transfer requests (TRs) through the three holding stages of a DMA transfer controller and raises interrupt events as they progress. A TR that software writes lands in a program stage. From there it passes to a source stage, where its reads are performed. It then waits in a bounded destination queue until the status for its last write has come back. No data moves through the block. The read engine, the write engine and the write-status return path appear only as handshakes: a read-completion handshake, a write-issue pulse and a write-status pulse.

TR submission and read completion use valid/ready handshakes. A transfer happens on a rising clock edge where both valid and ready are 1. The block removes `tr_ready` while the program stage is occupied, and removes `rd_ready` while the source stage is empty or the destination queue is full. The sender must hold valid until the transfer happens. Write issue and write status are single-cycle pulses that cannot be held off. A pulse that finds no eligible work is discarded.

Each TR carries a write count, and the queue keeps the number of write statuses each TR still awaits. A counter of writes that have been issued but not yet answered drives a pending flag. A small register port gives software three views: a status word, an interrupt status word, and a write-1-to-clear register for the interrupt bits. The interrupt line is the OR of the interrupt status bits.

Top module: `trq_tracker`

## Requirements
- R1: A TR is accepted on a clock edge where `tr_valid` and `tr_ready` are both 1. `tr_ready` is 1 exactly when the program stage is empty. Status bit 0 is 1 while the program stage holds a TR.
- R2: A TR in the program stage moves to the source stage on the next clock edge if the source stage is idle and the destination queue holds fewer than FIFO_DEPTH TRs. Otherwise the TR stays in the program stage.
- R3: Status bit 1 is 1 while the source stage holds a TR. `rd_ready` is 1 when the source stage is occupied and the queue is not full. A read handshake moves the TR into the queue. Status bits 6:4 give the queue occupancy, from 0 to FIFO_DEPTH (4 by default).
- R4: A `wr_issue` pulse while the queue is non-empty increments the outstanding-write counter. The counter saturates at its maximum. A `wr_stat` pulse decrements it. Status bit 2 is 1 while the counter is non-zero.
- R5: A `wr_issue` pulse while the queue is empty has no effect. A `wr_stat` pulse while the counter is zero or the queue is empty has no effect.
- R6: The queue head counts its accepted write statuses. When the status for its last write arrives, the head leaves the queue and interrupt status bit 1 (TR done) is set. A write count of 0 is treated as 1. Statuses before the last one set nothing.
- R7: Interrupt status bit 0 (program empty) is set on the clock edge where the program stage goes from occupied to empty.
- R8: A register write to address 2 clears each interrupt status bit whose `reg_wdata` bit is 1. A 0 in a `reg_wdata` bit leaves that interrupt bit unchanged. If a set event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R9: `reg_rdata` gives the status word at address 0 and the interrupt status word at address 1. It gives 0 at addresses 2 and 3. Status bits 31:7 and 3, and interrupt status bits 31:2, read as 0.
- R10: `irq` is 1 exactly when at least one interrupt status bit is 1.
- R11: After reset, all stages are empty, the counter is zero, all interrupt bits are 0 and `tr_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tr_valid | input | 1 | A TR is offered for the program stage |
| tr_ready | output | 1 | The program stage is free |
| tr_wcnt | input | WCNT_W | Number of writes the offered TR will perform |
| rd_valid | input | 1 | The reads of the source-stage TR are complete |
| rd_ready | output | 1 | The source stage can hand its TR to the queue |
| wr_issue | input | 1 | Pulse: one write command was issued |
| wr_stat | input | 1 | Pulse: one write status returned |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a full destination queue with a TR held back in the program stage and its tail still needing statuses. In that state, queue exit and program-stage advance fall on consecutive edges. The bench fills the queue one TR at a time and then submits a fifth TR, which must stay in the program stage. It drains the head one status at a time and lands the final status in the same cycle as a clear of both interrupt bits. This exercises the set-over-clear rule and the one-cycle-late advance together. The remaining queue entries are then drained, and occupancy and TR-done are checked after every status.

// File: rtl/trq_pkg.sv
package trq_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    RA_STATUS  = 2'd0,
    RA_INTSTAT = 2'd1,
    RA_INTCLR  = 2'd2,
    RA_SPARE   = 2'd3
  } reg_addr_e;

  // interrupt bit positions (decoded by software)
  localparam int IRQ_EMPTY_BIT = 0;
  localparam int IRQ_DONE_BIT  = 1;
  localparam int IRQ_N         = 2;

  // status word layout
  localparam int ST_PROG_BIT = 0;
  localparam int ST_SRC_BIT  = 1;
  localparam int ST_WPND_BIT = 2;
  localparam int ST_CNT_LSB  = 4;
endpackage

// File: rtl/trq_stage_ctrl.sv
module trq_stage_ctrl #(
  parameter int WCNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tr_valid,
  input  logic [WCNT_W-1:0] tr_wcnt,
  output logic              tr_ready,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic              fifo_full,
  output logic              prog_busy,
  output logic              src_busy,
  output logic [WCNT_W-1:0] src_wcnt,
  output logic              rd_fire,
  output logic              prog_empty_evt
);
  logic              prog_q, src_q;
  logic [WCNT_W-1:0] prog_wcnt_q, src_wcnt_q;
  logic              tr_fire, advance;

  assign tr_ready       = !prog_q;
  assign tr_fire        = tr_valid && tr_ready;
  assign advance        = prog_q && !src_q && !fifo_full;
  assign rd_ready       = src_q && !fifo_full;
  assign rd_fire        = rd_valid && rd_ready;
  assign prog_empty_evt = advance;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q      <= 1'b0;
      prog_wcnt_q <= '0;
    end else if (tr_fire) begin
      prog_q      <= 1'b1;
      prog_wcnt_q <= tr_wcnt;
    end else if (advance) begin
      prog_q      <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q      <= 1'b0;
      src_wcnt_q <= '0;
    end else if (advance) begin
      src_q      <= 1'b1;
      src_wcnt_q <= prog_wcnt_q;
    end else if (rd_fire) begin
      src_q      <= 1'b0;
    end
  end

  assign prog_busy = prog_q;
  assign src_busy  = src_q;
  assign src_wcnt  = src_wcnt_q;
endmodule

// File: rtl/trq_dst_fifo.sv
module trq_dst_fifo #(
  parameter int DEPTH  = 4,
  parameter int WCNT_W = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WCNT_W-1:0] push_wcnt,
  input  logic              stat,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty,
  output logic              pop
);
  localparam logic [WCNT_W-1:0] ONE    = WCNT_W'(1);
  localparam logic [PTR_W-1:0]  LASTP  = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0]  FULLC  = CNT_W'(DEPTH);

  logic [WCNT_W-1:0] rem_q [DEPTH];
  logic [PTR_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WCNT_W-1:0] load_val;
  logic              stat_hit;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == LASTP) ? '0 : p + PTR_W'(1);
  endfunction

  assign full     = (cnt_q == FULLC);
  assign empty    = (cnt_q == '0);
  assign load_val = (push_wcnt == '0) ? ONE : push_wcnt;
  assign stat_hit = stat && !empty;
  assign pop      = stat_hit && (rem_q[head_q] == ONE);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rem_q[i] <= '0;
      else if (push && !full && tail_q == PTR_W'(i))
        rem_q[i] <= load_val;
      else if (stat_hit && head_q == PTR_W'(i))
        rem_q[i] <= rem_q[i] - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push && !full) tail_q <= nxt(tail_q);
      if (pop)           head_q <= nxt(head_q);
      case ({push && !full, pop})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/trq_wr_counter.sv
module trq_wr_counter #(
  parameter int OUT_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  logic stat,
  input  logic fifo_empty,
  output logic issue_ok,
  output logic stat_ok,
  output logic pending
);
  logic [OUT_W-1:0] cnt_q;

  assign issue_ok = issue && !fifo_empty && (cnt_q != '1);
  assign stat_ok  = stat && !fifo_empty && (cnt_q != '0);
  assign pending  = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      case ({issue_ok, stat_ok})
        2'b10:   cnt_q <= cnt_q + OUT_W'(1);
        2'b01:   cnt_q <= cnt_q - OUT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
  end
endmodule

// File: rtl/trq_irq_regs.sv
module trq_irq_regs #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[i] <= 1'b0;
      else if (set_vec[i]) flag_q[i] <= 1'b1;
      else if (clr_vec[i]) flag_q[i] <= 1'b0;
    end
  end

  assign flags = flag_q;
  assign irq   = |flag_q;
endmodule

// File: rtl/trq_tracker.sv
module trq_tracker #(
  parameter int FIFO_DEPTH = 4,
  parameter int WCNT_W     = 4,
  parameter int OUT_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tr_valid,
  output logic              tr_ready,
  input  logic [WCNT_W-1:0] tr_wcnt,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic              wr_issue,
  input  logic              wr_stat,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  import trq_pkg::*;
  localparam int FCNT_W = $clog2(FIFO_DEPTH + 1);

  logic              prog_busy, src_busy, rd_fire, prog_empty_evt;
  logic [WCNT_W-1:0] src_wcnt;
  logic [FCNT_W-1:0] fifo_count;
  logic              fifo_full, fifo_empty, fifo_pop;
  logic              issue_ok, stat_ok, wr_pending;
  logic [IRQ_N-1:0]  set_vec, clr_vec, int_flags;
  logic [REG_W-1:0]  status_w, intstat_w;
  logic              tr_fire;

  assign tr_fire = tr_valid && tr_ready;

  trq_stage_ctrl #(.WCNT_W(WCNT_W)) i_stage (
    .clk, .rst_n, .tr_valid, .tr_wcnt, .tr_ready, .rd_valid, .rd_ready,
    .fifo_full, .prog_busy, .src_busy, .src_wcnt, .rd_fire, .prog_empty_evt
  );

  trq_dst_fifo #(.DEPTH(FIFO_DEPTH), .WCNT_W(WCNT_W)) i_fifo (
    .clk, .rst_n, .push(rd_fire), .push_wcnt(src_wcnt), .stat(stat_ok),
    .count(fifo_count), .full(fifo_full), .empty(fifo_empty), .pop(fifo_pop)
  );

  trq_wr_counter #(.OUT_W(OUT_W)) i_wcnt (
    .clk, .rst_n, .issue(wr_issue), .stat(wr_stat), .fifo_empty,
    .issue_ok, .stat_ok, .pending(wr_pending)
  );

  always_comb begin
    set_vec                = '0;
    set_vec[IRQ_EMPTY_BIT] = prog_empty_evt;
    set_vec[IRQ_DONE_BIT]  = fifo_pop;
    clr_vec = (reg_wr && reg_addr == RA_INTCLR) ? reg_wdata[IRQ_N-1:0] : '0;
  end

  trq_irq_regs #(.N(IRQ_N)) i_irq (
    .clk, .rst_n, .set_vec, .clr_vec, .flags(int_flags), .irq
  );

  always_comb begin
    status_w                         = '0;
    status_w[ST_PROG_BIT]            = prog_busy;
    status_w[ST_SRC_BIT]             = src_busy;
    status_w[ST_WPND_BIT]            = wr_pending;
    status_w[ST_CNT_LSB +: FCNT_W]   = fifo_count;
    intstat_w                        = '0;
    intstat_w[IRQ_N-1:0]             = int_flags;
    case (reg_addr)
      RA_STATUS:  reg_rdata = status_w;
      RA_INTSTAT: reg_rdata = intstat_w;
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/trq_tracker_chk.sv
module trq_tracker_chk #(
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tr_fire,
  input logic             prog_busy,
  input logic             rd_ready,
  input logic             fifo_full,
  input logic [CNT_W-1:0] fifo_count,
  input logic             fifo_pop,
  input logic             issue_ok,
  input logic             stat_ok,
  input logic             wr_pending,
  input logic [1:0]       set_vec,
  input logic [1:0]       clr_vec,
  input logic [1:0]       int_flags
);
  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tr_fire |=> prog_busy);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CNT_W'(DEPTH));
  assert_no_rd_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !rd_ready);
  assert_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_ok && !stat_ok) |=> wr_pending);
  assert_done_on_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> int_flags[1]);
  assert_empty_evt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_busy) |-> int_flags[0]);
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec[1] && clr_vec[1]) |=> int_flags[1]);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec[0] && !set_vec[0]) |=> !int_flags[0]);
endmodule

bind trq_tracker trq_tracker_chk #(.DEPTH(FIFO_DEPTH), .CNT_W(FCNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tr_fire(tr_fire), .prog_busy(prog_busy),
  .rd_ready(rd_ready), .fifo_full(fifo_full), .fifo_count(fifo_count),
  .fifo_pop(fifo_pop), .issue_ok(issue_ok), .stat_ok(stat_ok),
  .wr_pending(wr_pending), .set_vec(set_vec), .clr_vec(clr_vec),
  .int_flags(int_flags)
);

// File: tb/test_trq_tracker.sv
module test_trq_tracker;
  localparam int DEPTH = 4;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tr_valid = 0, rd_valid = 0, wr_issue = 0, wr_stat = 0, reg_wr = 0;
  logic [3:0]  tr_wcnt = '0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        tr_ready, rd_ready, irq;
  logic [31:0] reg_rdata;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  trq_tracker i_trq_tracker (
    .clk, .rst_n, .tr_valid, .tr_ready, .tr_wcnt, .rd_valid, .rd_ready,
    .wr_issue, .wr_stat, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata, .irq
  );

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_reg(input logic [1:0] a, input logic [31:0] exp, input string req);
    reg_addr = a; #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic put_tr(input logic [3:0] w);
    tr_valid = 1; tr_wcnt = w; cyc(); tr_valid = 0;
  endtask
  task automatic put_rd();   rd_valid = 1; cyc(); rd_valid = 0; endtask
  task automatic put_iss();  wr_issue = 1; cyc(); wr_issue = 0; endtask
  task automatic put_stat(); wr_stat  = 1; cyc(); wr_stat  = 0; endtask
  task automatic clr(input logic [31:0] v);
    reg_wr = 1; reg_addr = 2'd2; reg_wdata = v; cyc(); reg_wr = 0; reg_wdata = 0;
  endtask

  function automatic logic [31:0] st(input int cnt, input bit pend, input bit src, input bit prog);
    return (32'(cnt) << 4) | (32'(pend) << 2) | (32'(src) << 1) | 32'(prog);
  endfunction

  initial begin
    repeat (3) cyc();
    rst_n = 1; cyc();
    // R11 reset state, R9 unused address
    expect_reg(0, 0, "R11 status");
    expect_reg(1, 0, "R11 intstat");
    chk("R11 tr_ready", tr_ready, 1);
    chk("R10 irq idle", irq, 0);
    expect_reg(3, 0, "R9 spare addr");

    // single TR, write count 0 treated as 1
    put_tr(0);
    expect_reg(0, st(0,0,0,1), "R1 prog busy");
    chk("R1 tr_ready low", tr_ready, 0);
    cyc();
    expect_reg(0, st(0,0,1,0), "R2 moved to source");
    expect_reg(1, 32'h1, "R7 prog empty");
    chk("R10 irq set", irq, 1);
    chk("R3 rd_ready", rd_ready, 1);
    clr(0);
    expect_reg(1, 32'h1, "R8 write 0 no effect");
    expect_reg(2, 0, "R9 clear reads 0");
    clr(1);
    expect_reg(1, 0, "R8 cleared");
    chk("R10 irq clear", irq, 0);
    put_rd();
    expect_reg(0, st(1,0,0,0), "R3 queued");
    put_iss();
    expect_reg(0, st(1,1,0,0), "R4 pending");
    put_stat();
    expect_reg(0, st(0,0,0,0), "R6 popped");
    expect_reg(1, 32'h2, "R6 done set");
    clr(3);
    put_stat();
    expect_reg(0, 0, "R5 stat ignored");
    expect_reg(1, 0, "R5 no done");
    put_iss();
    expect_reg(0, 0, "R5 issue ignored when empty");

    // fill queue to each level
    for (int k = 1; k <= DEPTH; k++) begin
      put_tr(2); cyc(); put_rd();
      expect_reg(0, st(k,0,0,0), "R3 fill level");
    end
    chk("R3 rd_ready full", rd_ready, 0);
    clr(3);
    put_tr(3); cyc(); cyc();
    expect_reg(0, st(DEPTH,0,0,1), "R2 held by full queue");
    expect_reg(1, 0, "R7 no event while held");
    put_iss(); put_iss();
    expect_reg(0, st(DEPTH,1,0,1), "R4 two outstanding");
    put_stat();
    expect_reg(0, st(DEPTH,1,0,1), "R6 partial keeps entry");
    expect_reg(1, 0, "R6 partial no done");
    wr_stat = 1; reg_wr = 1; reg_addr = 2'd2; reg_wdata = 3;
    cyc();
    wr_stat = 0; reg_wr = 0; reg_wdata = 0;
    expect_reg(1, 32'h2, "R8 set wins over clear");
    expect_reg(0, st(DEPTH-1,0,0,1), "R6 pop from full");
    cyc();
    expect_reg(0, st(DEPTH-1,0,1,0), "R2 advance after pop");
    expect_reg(1, 32'h3, "R7 empty after advance");
    put_rd();
    expect_reg(0, st(DEPTH,0,0,0), "R3 refill");

    // drain remaining entries: counts 2,2,2,3
    for (int j = 0; j < DEPTH; j++) begin
      int w;
      w = (j == DEPTH-1) ? 3 : 2;
      clr(3);
      for (int i = 0; i < w; i++) put_iss();
      expect_reg(0, st(DEPTH-j,1,0,0), "R4 drain pending");
      for (int s = 0; s < w; s++) begin
        put_stat();
        if (s < w-1) begin
          expect_reg(1, 0, "R6 drain partial");
          expect_reg(0, st(DEPTH-j,1,0,0), "R6 drain keep");
        end else begin
          expect_reg(1, 32'h2, "R6 drain done");
          expect_reg(0, st(DEPTH-1-j,0,0,0), "R6 drain pop");
        end
      end
    end
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule